// File: doc/BRIEF.md
# Carrier-Clocked Line Encoder

This block turns a serial bit stream into a modulation-control level for a load-modulating transponder front end. Its only clock is recovered from the reader's carrier, one tick per field period. Bit cells are therefore measured in carrier periods rather than in time. A cell timer counts those periods. At the first cycle of each cell it raises a bit strobe, and the data source presents the next bit on that same cycle.

One engine provides three line codes: Manchester, biphase and phase-shift keying. The code and the cell length are static configuration inputs. They are captured while reset is high and hold until the next reset. The output level feeds the switch that loads the coil. The coil drive itself, rectification and clock recovery sit outside this block.

Top module: `carrier_bit_encoder`

## Requirements
- R1: While `rst` is high, `mod_out` and `bit_strobe` are both 0, and `mod_out` stays 0 in the first cycle after `rst` falls.
- R2: `bit_strobe` is 1 in the first cycle after reset and then for exactly one cycle in every L cycles, where L is the cell length.
- R3: When `mode_sel[1]` is 0, L is 64 if `rate_sel` is 0 and 32 if `rate_sel` is 1.
- R4: When `mode_sel[1]` is 1 the code is PSK and L is 16, whatever `rate_sel` holds (`mode_sel` values 2 and 3 both select PSK).
- R5: In Manchester mode (`mode_sel` = 0), the output for a bit sampled in strobe cycle t0 is the bit for cycles t0+1 to t0+L/2 and its inverse for cycles t0+L/2+1 to t0+L.
- R6: In biphase mode (`mode_sel` = 1), the output inverts at the start of every cell (cycle t0+1), and inverts again at mid-cell (cycle t0+L/2+1) only when the bit is 0.
- R7: In PSK mode the output inverts on every cycle, except that a bit of 1 sampled in strobe cycle t0 holds the level across cycles t0 and t0+1, which inverts the subcarrier phase.
- R8: `data_in` is sampled only in a cycle where `bit_strobe` is 1, and its value in any other cycle has no effect on `mod_out`.
- R9: A change of `mode_sel` or `rate_sel` while `rst` is low has no effect; the new values apply from the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock recovered from the carrier, one rising edge per field period |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| mode_sel | input | 2 | Line code: 0 Manchester, 1 biphase, 2 or 3 PSK |
| rate_sel | input | 1 | Cell length for Manchester/biphase: 0 gives 64 periods, 1 gives 32 |
| data_in | input | 1 | Next bit to send, taken in the strobe cycle |
| mod_out | output | 1 | Modulation-control level |
| bit_strobe | output | 1 | One-cycle request for the next bit at each cell start |

## Verification
Every code is run at each cell length it allows. Each run uses four bit patterns, and each pattern isolates something different. All zeros and all ones show the two fixed cell shapes of each code. Alternating bits show that state carries correctly from one cell to the next. A scrambled sequence tests mixed neighbours.

Every cycle of every run is compared with a level computed in closed form from the cycle index and the number of ones or zeros sent so far. Outside strobe cycles, `data_in` is driven to the inverse of the real bit, which exposes sampling at the wrong time. Both configuration inputs are inverted right after each reset release. A configuration change that leaks through without a reset therefore changes the cell length or the code, and the comparison reports it.

// File: rtl/carrier_enc_pkg.sv
package carrier_enc_pkg;

    typedef enum logic [1:0] {
        LC_MANCH   = 2'd0,
        LC_BIPHASE = 2'd1,
        LC_PSK     = 2'd2
    } line_code_e;

    // Configuration input value to line code: the upper bit alone selects PSK.
    function automatic line_code_e decode_code(input logic [1:0] sel);
        if (sel[1])
            return LC_PSK;
        else if (sel[0])
            return LC_BIPHASE;
        else
            return LC_MANCH;
    endfunction

    // Cell length in carrier periods for a code and a rate choice.
    function automatic int cell_periods(input line_code_e code, input logic fast,
                                        input int slow_len, input int fast_len,
                                        input int psk_len);
        if (code == LC_PSK)
            return psk_len;
        else if (fast)
            return fast_len;
        else
            return slow_len;
    endfunction

    // Actions the timer hands to the coder for the current cycle.
    typedef struct packed {
        logic cell_start;
        logic cell_mid;
    } cell_event_t;

endpackage

// File: rtl/enc_cfg_latch.sv
module enc_cfg_latch
    import carrier_enc_pkg::*;
#(
    parameter int CELL_SLOW = 64,
    parameter int CELL_FAST = 32,
    parameter int CELL_PSK  = 16,
    parameter int CW        = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             rate_sel,
    output line_code_e       code,
    output logic [CW-1:0]    cell_len
);

    line_code_e    code_q;
    logic [CW-1:0] len_q;

    // Configuration is frozen outside reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= decode_code(mode_sel);
            len_q  <= CW'(cell_periods(decode_code(mode_sel), rate_sel,
                                       CELL_SLOW, CELL_FAST, CELL_PSK));
        end
    end

    assign code     = code_q;
    assign cell_len = len_q;

endmodule

// File: rtl/enc_cell_timer.sv
module enc_cell_timer
    import carrier_enc_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cell_len,
    output cell_event_t   ev
);

    logic [CW-1:0] phase_q;
    logic [CW-1:0] last_idx;
    logic [CW-1:0] half_idx;

    assign last_idx = cell_len - CW'(1);
    assign half_idx = cell_len >> 1;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (phase_q == last_idx)
            phase_q <= '0;
        else
            phase_q <= phase_q + CW'(1);
    end

    assign ev.cell_start = !rst && (phase_q == '0);
    assign ev.cell_mid   = !rst && (phase_q == half_idx);

endmodule

// File: rtl/enc_line_coder.sv
module enc_line_coder
    import carrier_enc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  line_code_e  code,
    input  cell_event_t ev,
    input  logic        data_in,
    output logic        level
);

    logic level_q;
    logic bit_q;
    logic level_d;

    always_comb begin
        level_d = level_q;
        unique case (code)
            LC_MANCH: begin
                if (ev.cell_start)
                    level_d = data_in;
                else if (ev.cell_mid)
                    level_d = !bit_q;
            end
            LC_BIPHASE: begin
                if (ev.cell_start)
                    level_d = !level_q;
                else if (ev.cell_mid && !bit_q)
                    level_d = !level_q;
            end
            LC_PSK: begin
                if (ev.cell_start && data_in)
                    level_d = level_q;
                else
                    level_d = !level_q;
            end
            default: level_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            level_q <= level_d;
            if (ev.cell_start)
                bit_q <= data_in;
        end
    end

    assign level = level_q;

endmodule

// File: rtl/carrier_bit_encoder.sv
module carrier_bit_encoder
    import carrier_enc_pkg::*;
#(
    parameter int CELL_SLOW = 64,
    parameter int CELL_FAST = 32,
    parameter int CELL_PSK  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       rate_sel,
    input  logic       data_in,
    output logic       mod_out,
    output logic       bit_strobe
);

    localparam int CW = $clog2(CELL_SLOW) + 1;

    line_code_e    code;
    logic [CW-1:0] cell_len;
    cell_event_t   ev;

    enc_cfg_latch #(
        .CELL_SLOW(CELL_SLOW),
        .CELL_FAST(CELL_FAST),
        .CELL_PSK (CELL_PSK),
        .CW       (CW)
    ) i_cfg (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .rate_sel (rate_sel),
        .code     (code),
        .cell_len (cell_len)
    );

    enc_cell_timer #(
        .CW(CW)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .cell_len (cell_len),
        .ev       (ev)
    );

    enc_line_coder i_coder (
        .clk     (clk),
        .rst     (rst),
        .code    (code),
        .ev      (ev),
        .data_in (data_in),
        .level   (mod_out)
    );

    assign bit_strobe = ev.cell_start;

endmodule

// File: rtl/enc_checker.sv
module enc_checker #(
    parameter int CELL_SLOW = 64,
    parameter int CELL_FAST = 32,
    parameter int CELL_PSK  = 16
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       rate_sel,
    input logic       data_in,
    input logic       mod_out,
    input logic       bit_strobe
);

    int   exp_len;
    logic is_psk;
    logic is_bi;
    logic is_manch;
    int   gap;
    logic seen;

    // Own view of the configuration captured at reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            is_psk   <= mode_sel[1];
            is_bi    <= (mode_sel == 2'd1);
            is_manch <= (mode_sel == 2'd0);
            exp_len  <= mode_sel[1] ? CELL_PSK : (rate_sel ? CELL_FAST : CELL_SLOW);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (bit_strobe) begin
            gap  <= 0;
            seen <= 1'b1;
        end else begin
            gap <= gap + 1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |-> !bit_strobe);
    a_r1_reset_low:   assert property (@(posedge clk) rst |=> !mod_out);

    // R2, R3, R4
    a_r2_strobe_period: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && seen) |-> (gap == exp_len - 1));
    a_r2_no_late_strobe: assert property (@(posedge clk) disable iff (rst)
        (seen && !bit_strobe) |-> (gap < exp_len - 1));

    // R5
    a_r5_manch_first_half: assert property (@(posedge clk) disable iff (rst)
        (is_manch && bit_strobe) |=> (mod_out == $past(data_in)));

    // R6
    a_r6_biphase_edge: assert property (@(posedge clk) disable iff (rst)
        (is_bi && bit_strobe) |=> (mod_out != $past(mod_out)));

    // R7
    a_r7_psk_toggle: assert property (@(posedge clk) disable iff (rst)
        (is_psk && !bit_strobe) |=> (mod_out != $past(mod_out)));
    a_r7_psk_flip: assert property (@(posedge clk) disable iff (rst)
        (is_psk && bit_strobe && data_in) |=> (mod_out == $past(mod_out)));

endmodule

bind carrier_bit_encoder enc_checker #(
    .CELL_SLOW(CELL_SLOW),
    .CELL_FAST(CELL_FAST),
    .CELL_PSK (CELL_PSK)
) i_enc_checker (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .rate_sel   (rate_sel),
    .data_in    (data_in),
    .mod_out    (mod_out),
    .bit_strobe (bit_strobe)
);

// File: tb/test_carrier_bit_encoder.sv
`timescale 1ns/1ps
module test_carrier_bit_encoder;

    localparam int NCELLS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'd0;
    logic       rate_sel = 1'b0;
    logic       data_in = 1'b0;
    logic       mod_out;
    logic       bit_strobe;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    carrier_bit_encoder i_carrier_bit_encoder (
        .clk        (clk),
        .rst        (rst),
        .mode_sel   (mode_sel),
        .rate_sel   (rate_sel),
        .data_in    (data_in),
        .mod_out    (mod_out),
        .bit_strobe (bit_strobe)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit pat_bit(input int kind, input int k);
        case (kind)
            0: return 1'b0;
            1: return 1'b1;
            2: return k[0];
            default: return bit'(((k * 37 + 11) >> 2) & 1);
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input int i);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%b expected=%b", req, i, act, exp);
        end
    endtask

    // One run: reset with (m, r), then invert both inputs (R9) and send NCELLS cells.
    task automatic run(input logic [1:0] m, input logic r, input int kind);
        int  len;
        int  half;
        int  ncyc;
        bit  exp_o;
        bit  exp_s;
        @(negedge clk);
        rst = 1'b1; mode_sel = m; rate_sel = r;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            #1;
            check("R1", mod_out, 1'b0, -1);
            check("R1", bit_strobe, 1'b0, -1);
        end
        // R3, R4: expected cell length
        len  = m[1] ? 16 : (r ? 32 : 64);
        half = len / 2;
        ncyc = len * NCELLS;
        for (int i = 0; i < ncyc; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 0) begin
                rst = 1'b0;
                mode_sel = ~m;   // R9: must be ignored until next reset
                rate_sel = ~r;
            end
            // R8: wrong value outside strobe cycles
            data_in = (i % len == 0) ? pat_bit(kind, i / len) : ~pat_bit(kind, i / len);
            #1;
            exp_s = (i % len == 0);
            check(r == 1'b1 ? "R2/R3 strobe fast" : "R2/R3 strobe slow", bit_strobe, exp_s, i);
            if (i == 0) begin
                exp_o = 1'b0;
                check("R1 first cycle", mod_out, exp_o, i);
            end else begin
                int k   = (i - 1) / len;
                int pos = (i - 1) % len;
                bit d   = pat_bit(kind, k);
                int cnt = 0;
                if (m == 2'd0) begin
                    exp_o = (pos < half) ? d : ~d;
                    check("R5/R8/R9 manchester", mod_out, exp_o, i);
                end else if (m == 2'd1) begin
                    cnt = k + 1;
                    for (int j = 0; j < k; j++) if (!pat_bit(kind, j)) cnt++;
                    if (pos >= half && !d) cnt++;
                    exp_o = bit'(cnt & 1);
                    check("R6/R8/R9 biphase", mod_out, exp_o, i);
                end else begin
                    cnt = i;
                    for (int j = 0; j <= k; j++) if (pat_bit(kind, j)) cnt--;
                    exp_o = bit'(cnt & 1);
                    check("R4/R7/R8/R9 psk", mod_out, exp_o, i);
                end
            end
        end
    endtask

    initial begin
        for (int kind = 0; kind < 4; kind++) begin
            run(2'd0, 1'b0, kind);
            run(2'd0, 1'b1, kind);
            run(2'd1, 1'b0, kind);
            run(2'd1, 1'b1, kind);
            run(2'd2, 1'b0, kind);
            run(2'd3, 1'b1, kind);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule